// File: doc/BRIEF.md
# Floating-Point Constant Push Unit

This block executes the seven floating-point constant-load instructions. When a valid strobe arrives carrying the escape byte 0xD9 and a selector byte from 0xE8 to 0xEE, the unit picks one of seven built-in constants: +1.0, log2(10), log2(e), pi, log10(2), ln(2) and +0.0. It rounds that constant to the 80-bit double-extended format under a 2-bit rounding mode and pushes the result onto an eight-register stack. The stack keeps a 3-bit top pointer and one occupied bit per register.

Each irrational constant is stored with two bits below the 64-bit significand, plus an implicit nonzero tail. Rounding is therefore correct in every mode. Rounding never reports inexactness and never touches C1. A push onto an occupied register is a stack overflow: it sets C1 and signals a stack fault. If the invalid-operation exception is masked, that push also loads the indefinite quiet NaN. Instructions blocked by a lock prefix, by the emulation or task-switched bits, or by a pending floating-point exception leave the whole stack untouched and report a single fault.

The stack contents are visible on a flat image port. Register i occupies bits [80i+79:80i]. Within a register, the sign is bit 79, the exponent is bits 78:64 and the significand is bits 63:0.

Top module: `fconst_push_unit`

## Requirements
- R1: Only an escape byte of 0xD9 with a selector of 0xE8..0xEE, sampled while instValid is high, is acted on. Any other byte pair, or a pair presented while instValid is low, changes no output: done stays 0, and topPtr, tagValid, c1Flag and stackImage keep their values.
- R2: In round-to-nearest (roundMode 00), the pushed value (sign, exponent hex, significand hex) is as follows. E8: 0,3FFF,8000000000000000. E9: 0,4000,D49A784BCD1B8AFE. EA: 0,3FFF,B8AA3B295C17F0BC. EB: 0,4000,C90FDAA22168C235. EC: 0,3FFD,9A209A84FBCFF799. ED: 0,3FFE,B17217F7D1CF79AC. EE: all zero.
- R3: roundMode 01 (toward minus infinity) and 11 (toward zero) give the truncated significands: E9 ..8AFE, EA ..F0BB, EB ..C234, EC ..F798, ED ..79AB. roundMode 10 (toward plus infinity) gives those truncated significands plus one. E8 and EE give the same result in every mode.
- R4: An executed push decrements topPtr modulo 8 (0 goes to 7), writes the new top register and sets its tagValid bit. All of this happens at the clock edge that samples instValid. No other register changes.
- R5: An executed push onto an empty register clears c1Flag. A push whose new top register is already occupied sets c1Flag, and stackFault is high for one cycle.
- R6: On overflow with invMasked=1, topPtr decrements and the new top register receives sign 1, exponent 7FFF, significand C000000000000000. On overflow with invMasked=0, topPtr, tagValid and stackImage are unchanged.
- R7: A push that was rounded upward leaves c1Flag at 0.
- R8: Fault priority is fixed. A lock prefix raises undefOp. Otherwise, emuCtl or taskSwitch raises devNotAvail. Otherwise, pendingExc raises pendFault. At most one of undefOp, devNotAvail, pendFault and stackFault is high in any cycle.
- R9: A faulting instruction leaves topPtr, tagValid, stackImage and c1Flag unchanged, and it does not raise done or stackFault.
- R10: done, undefOp, devNotAvail, pendFault and stackFault are each high for exactly the one cycle after the sampling edge. done marks an executed push, including one that overflows.
- R11: After reset, topPtr is 0, tagValid is 0, stackImage is 0, c1Flag is 0 and every pulse output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction strobe |
| escByte | input | 8 | First opcode byte |
| selByte | input | 8 | Second opcode byte, selects the constant |
| lockPrefix | input | 1 | Lock prefix present |
| roundMode | input | 2 | Rounding mode: 00 nearest-even, 01 down, 10 up, 11 zero |
| emuCtl | input | 1 | Emulation control bit |
| taskSwitch | input | 1 | Task-switched control bit |
| pendingExc | input | 1 | Unserviced floating-point exception pending |
| invMasked | input | 1 | Invalid-operation exception masked |
| stackImage | output | 640 | All eight stack registers, register i at [80i+79:80i] |
| topPtr | output | 3 | Top-of-stack pointer |
| tagValid | output | 8 | Occupied bit per register |
| c1Flag | output | 1 | Condition bit C1 |
| stackFault | output | 1 | Stack overflow pulse |
| devNotAvail | output | 1 | Device-not-available pulse |
| undefOp | output | 1 | Invalid-opcode pulse |
| pendFault | output | 1 | Pending-exception fault pulse |
| done | output | 1 | Push executed pulse |

## Verification
A single push can combine an upward rounding with a stack overflow. The bench provokes this by filling all eight registers and then pushing pi in round-up mode with invalid masked. It then requires the indefinite NaN rather than the rounded constant in the new top, c1Flag high because of the overflow, and a stackFault pulse. A lock prefix on the same full stack tests the other collision, between a fault and an overflow. The bench requires only undefOp, with no stackFault, no change to c1Flag and no move of the pointer.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  localparam int EXT_W   = 80;
  localparam int SIG_W   = 64;
  localparam int EXP_W   = 15;
  localparam int GUARD_W = 2;
  localparam int WIDE_W  = SIG_W + GUARD_W;
  localparam int SEL_W   = 3;

  localparam logic [7:0] ESC_BYTE = 8'hD9;
  localparam logic [4:0] SEL_HIGH = 5'b11101;
  localparam logic [SEL_W-1:0] SEL_UNUSED = 3'b111;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } roundMode_e;

  typedef struct packed {
    logic [WIDE_W-1:0] wide;
    logic              exact;
    logic [EXP_W-1:0]  expo;
  } constRec_t;

  typedef struct packed {
    logic             pushEn;
    logic             writeNan;
    logic             updC1;
    logic             c1Val;
    logic [SEL_W-1:0] constIdx;
  } strobe_t;

  localparam logic [EXT_W-1:0] INDEF_NAN = {1'b1, 15'h7FFF, 64'hC000000000000000};

  function automatic constRec_t constLookup(input logic [SEL_W-1:0] idx);
    constRec_t r;
    case (idx)
      3'd0: r = '{wide: {64'h8000000000000000, 2'b00}, exact: 1'b1, expo: 15'h3FFF};
      3'd1: r = '{wide: {64'hD49A784BCD1B8AFE, 2'b01}, exact: 1'b0, expo: 15'h4000};
      3'd2: r = '{wide: {64'hB8AA3B295C17F0BB, 2'b10}, exact: 1'b0, expo: 15'h3FFF};
      3'd3: r = '{wide: {64'hC90FDAA22168C234, 2'b11}, exact: 1'b0, expo: 15'h4000};
      3'd4: r = '{wide: {64'h9A209A84FBCFF798, 2'b10}, exact: 1'b0, expo: 15'h3FFD};
      3'd5: r = '{wide: {64'hB17217F7D1CF79AB, 2'b11}, exact: 1'b0, expo: 15'h3FFE};
      default: r = '{wide: '0, exact: 1'b1, expo: '0};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fcp_round.sv
module fcp_round
  import fcp_pkg::*;
(
  input  logic [SEL_W-1:0] constIdx,
  input  logic [1:0]       roundMode,
  output logic [EXT_W-1:0] roundedVal
);
  constRec_t            rec;
  logic [SIG_W-1:0]     sigTrunc;
  logic                 roundBit;
  logic                 stickyBit;
  logic                 bumpUp;
  logic [SIG_W:0]       sigSum;
  logic [SIG_W-1:0]     sigOut;
  logic [EXP_W-1:0]     expOut;

  always_comb begin
    rec       = constLookup(constIdx);
    sigTrunc  = rec.wide[WIDE_W-1:GUARD_W];
    roundBit  = rec.wide[GUARD_W-1];
    // irrational constants carry a nonzero tail beyond the stored bits
    stickyBit = (|rec.wide[GUARD_W-2:0]) | ~rec.exact;
    case (roundMode_e'(roundMode))
      RND_NEAR: bumpUp = roundBit & (stickyBit | sigTrunc[0]);
      RND_UP:   bumpUp = roundBit | stickyBit;
      default:  bumpUp = 1'b0;
    endcase
    sigSum = {1'b0, sigTrunc} + {{SIG_W{1'b0}}, bumpUp};
    if (sigSum[SIG_W]) begin
      sigOut = {1'b1, {(SIG_W-1){1'b0}}};
      expOut = rec.expo + {{(EXP_W-1){1'b0}}, 1'b1};
    end else begin
      sigOut = sigSum[SIG_W-1:0];
      expOut = rec.expo;
    end
    roundedVal = {1'b0, expOut, sigOut};
  end
endmodule

// File: rtl/fcp_ctrl.sv
module fcp_ctrl
  import fcp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic [7:0] escByte,
  input  logic [7:0] selByte,
  input  logic       lockPrefix,
  input  logic       emuCtl,
  input  logic       taskSwitch,
  input  logic       pendingExc,
  input  logic       invMasked,
  input  logic       tagAtNext,
  output strobe_t    strb,
  output logic       stackFault,
  output logic       devNotAvail,
  output logic       undefOp,
  output logic       pendFault,
  output logic       done
);
  logic isConst, faultUd, faultNm, faultMf, execOk, overflow;

  always_comb begin
    isConst  = instValid && (escByte == ESC_BYTE) &&
               (selByte[7:SEL_W] == SEL_HIGH) && (selByte[SEL_W-1:0] != SEL_UNUSED);
    faultUd  = isConst && lockPrefix;
    faultNm  = isConst && !lockPrefix && (emuCtl || taskSwitch);
    faultMf  = isConst && !lockPrefix && !emuCtl && !taskSwitch && pendingExc;
    execOk   = isConst && !faultUd && !faultNm && !faultMf;
    overflow = execOk && tagAtNext;

    strb.pushEn   = execOk && (!overflow || invMasked);
    strb.writeNan = overflow;
    strb.updC1    = execOk;
    strb.c1Val    = overflow;
    strb.constIdx = selByte[SEL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stackFault  <= 1'b0;
      devNotAvail <= 1'b0;
      undefOp     <= 1'b0;
      pendFault   <= 1'b0;
      done        <= 1'b0;
    end else begin
      stackFault  <= overflow;
      devNotAvail <= faultNm;
      undefOp     <= faultUd;
      pendFault   <= faultMf;
      done        <= execOk;
    end
  end

  a_r8_single_fault: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({undefOp, devNotAvail, pendFault, stackFault}));

  a_r9_fault_not_done: assert property (@(posedge clk) disable iff (!rstN)
    (undefOp || devNotAvail || pendFault) |-> !done);

  a_r10_pulse_once: assert property (@(posedge clk) disable iff (!rstN)
    (done && !$past(instValid)) |-> 1'b0);
endmodule

// File: rtl/fcp_datapath.sv
module fcp_datapath
  import fcp_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strb,
  input  logic [1:0]                roundMode,
  output logic [NUM_REGS*EXT_W-1:0] stackImage,
  output logic [PTR_W-1:0]          topPtr,
  output logic [NUM_REGS-1:0]       tagValid,
  output logic                      c1Flag,
  output logic                      tagAtNext
);
  logic [PTR_W-1:0] nextTop;
  logic [EXT_W-1:0] roundedVal;
  logic [EXT_W-1:0] writeVal;

  fcp_round u_round (
    .constIdx  (strb.constIdx),
    .roundMode (roundMode),
    .roundedVal(roundedVal)
  );

  assign nextTop   = topPtr - PTR_W'(1);
  assign tagAtNext = tagValid[nextTop];
  assign writeVal  = strb.writeNan ? INDEF_NAN : roundedVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topPtr <= '0;
      c1Flag <= 1'b0;
    end else begin
      if (strb.pushEn) topPtr <= nextTop;
      if (strb.updC1)  c1Flag <= strb.c1Val;
    end
  end

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    logic [EXT_W-1:0] regVal;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regVal       <= '0;
        tagValid[gi] <= 1'b0;
      end else if (strb.pushEn && (nextTop == PTR_W'(gi))) begin
        regVal       <= writeVal;
        tagValid[gi] <= 1'b1;
      end
    end
    assign stackImage[gi*EXT_W +: EXT_W] = regVal;
  end

  a_r4_top_moves: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushEn |=> (topPtr == $past(topPtr) - PTR_W'(1)));

  a_r4_tag_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushEn |=> tagValid[topPtr]);

  a_r9_stack_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pushEn |=> ($stable(topPtr) && $stable(tagValid) && $stable(stackImage)));

  a_r7_c1_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.updC1 |=> $stable(c1Flag));
endmodule

// File: rtl/fconst_push_unit.sv
module fconst_push_unit
  import fcp_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      instValid,
  input  logic [7:0]                escByte,
  input  logic [7:0]                selByte,
  input  logic                      lockPrefix,
  input  logic [1:0]                roundMode,
  input  logic                      emuCtl,
  input  logic                      taskSwitch,
  input  logic                      pendingExc,
  input  logic                      invMasked,
  output logic [NUM_REGS*EXT_W-1:0] stackImage,
  output logic [PTR_W-1:0]          topPtr,
  output logic [NUM_REGS-1:0]       tagValid,
  output logic                      c1Flag,
  output logic                      stackFault,
  output logic                      devNotAvail,
  output logic                      undefOp,
  output logic                      pendFault,
  output logic                      done
);
  strobe_t strb;
  logic    tagAtNext;

  fcp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instValid  (instValid),
    .escByte    (escByte),
    .selByte    (selByte),
    .lockPrefix (lockPrefix),
    .emuCtl     (emuCtl),
    .taskSwitch (taskSwitch),
    .pendingExc (pendingExc),
    .invMasked  (invMasked),
    .tagAtNext  (tagAtNext),
    .strb       (strb),
    .stackFault (stackFault),
    .devNotAvail(devNotAvail),
    .undefOp    (undefOp),
    .pendFault  (pendFault),
    .done       (done)
  );

  fcp_datapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .roundMode (roundMode),
    .stackImage(stackImage),
    .topPtr    (topPtr),
    .tagValid  (tagValid),
    .c1Flag    (c1Flag),
    .tagAtNext (tagAtNext)
  );

  a_r5_fault_sets_c1: assert property (@(posedge clk) disable iff (!rstN)
    stackFault |-> c1Flag);
endmodule

// File: tb/test_fconst_push_unit.sv
module test_fconst_push_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic         instValid;
  logic [7:0]   escByte, selByte;
  logic         lockPrefix;
  logic [1:0]   roundMode;
  logic         emuCtl, taskSwitch, pendingExc, invMasked;
  logic [639:0] stackImage;
  logic [2:0]   topPtr;
  logic [7:0]   tagValid;
  logic         c1Flag, stackFault, devNotAvail, undefOp, pendFault, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fconst_push_unit i_fconst_push_unit (
    .clk(clk), .rstN(rstN), .instValid(instValid), .escByte(escByte), .selByte(selByte),
    .lockPrefix(lockPrefix), .roundMode(roundMode), .emuCtl(emuCtl), .taskSwitch(taskSwitch),
    .pendingExc(pendingExc), .invMasked(invMasked), .stackImage(stackImage), .topPtr(topPtr),
    .tagValid(tagValid), .c1Flag(c1Flag), .stackFault(stackFault), .devNotAvail(devNotAvail),
    .undefOp(undefOp), .pendFault(pendFault), .done(done)
  );

  function automatic logic [79:0] nearVal(input int k);
    case (k)
      0: return {1'b0, 15'h3FFF, 64'h8000000000000000};
      1: return {1'b0, 15'h4000, 64'hD49A784BCD1B8AFE};
      2: return {1'b0, 15'h3FFF, 64'hB8AA3B295C17F0BC};
      3: return {1'b0, 15'h4000, 64'hC90FDAA22168C235};
      4: return {1'b0, 15'h3FFD, 64'h9A209A84FBCFF799};
      5: return {1'b0, 15'h3FFE, 64'hB17217F7D1CF79AC};
      default: return 80'h0;
    endcase
  endfunction

  function automatic logic [79:0] truncVal(input int k);
    case (k)
      1: return {1'b0, 15'h4000, 64'hD49A784BCD1B8AFE};
      2: return {1'b0, 15'h3FFF, 64'hB8AA3B295C17F0BB};
      3: return {1'b0, 15'h4000, 64'hC90FDAA22168C234};
      4: return {1'b0, 15'h3FFD, 64'h9A209A84FBCFF798};
      5: return {1'b0, 15'h3FFE, 64'hB17217F7D1CF79AB};
      default: return nearVal(k);
    endcase
  endfunction

  function automatic logic [79:0] expVal(input int k, input logic [1:0] rm);
    if (k == 0 || k == 6) return nearVal(k);
    case (rm)
      2'b00: return nearVal(k);
      2'b10: return truncVal(k) + 80'd1;
      default: return truncVal(k);
    endcase
  endfunction

  function automatic logic [79:0] regAt(input int idx);
    return stackImage[idx*80 +: 80];
  endfunction

  task automatic check(input string req, input string what, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    instValid = 0; escByte = 8'h00; selByte = 8'h00; lockPrefix = 0; roundMode = 2'b00;
    emuCtl = 0; taskSwitch = 0; pendingExc = 0; invMasked = 1;
  endtask

  task automatic doReset();
    @(negedge clk);
    idleInputs();
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  // drive at a falling edge, outputs are checked at the next falling edge
  task automatic issue(input logic v, input logic [7:0] e, input logic [7:0] s, input logic lk,
                       input logic [1:0] rm, input logic em, input logic ts, input logic pe,
                       input logic mk);
    @(negedge clk);
    instValid = v; escByte = e; selByte = s; lockPrefix = lk; roundMode = rm;
    emuCtl = em; taskSwitch = ts; pendingExc = pe; invMasked = mk;
    @(negedge clk);
    idleInputs();
  endtask

  task automatic t_reset();
    doReset();
    check("R11", "topPtr", 80'(topPtr), 80'd0);
    check("R11", "tagValid", 80'(tagValid), 80'd0);
    check("R11", "c1Flag", 80'(c1Flag), 80'd0);
    check("R11", "pulses", 80'({stackFault, devNotAvail, undefOp, pendFault, done}), 80'd0);
    check("R11", "image", 80'(|stackImage), 80'd0);
  endtask

  task automatic t_push_modes(input logic [1:0] rm);
    doReset();
    for (int k = 0; k < 7; k++) begin
      issue(1, 8'hD9, 8'hE8 + 8'(k), 0, rm, 0, 0, 0, 1);
      check("R4", "topPtr", 80'(topPtr), 80'((8 - (k + 1)) % 8));
      check("R4", "tag", 80'(tagValid[topPtr]), 80'd1);
      check(rm == 2'b00 ? "R2" : "R3", "value", regAt(int'(topPtr)), expVal(k, rm));
      check("R10", "done", 80'(done), 80'd1);
      check("R7", "c1Flag", 80'(c1Flag), 80'd0);
      check("R5", "stackFault", 80'(stackFault), 80'd0);
      if (k == 0) check("R4", "reg0 untouched", regAt(0), 80'd0);
    end
    @(negedge clk);
    check("R10", "done falls", 80'(done), 80'd0);
  endtask

  task automatic t_ignore();
    logic [639:0] snap;
    doReset();
    issue(1, 8'hD9, 8'hEB, 0, 2'b00, 0, 0, 0, 1);
    snap = stackImage;
    issue(1, 8'hD8, 8'hE8, 0, 2'b00, 0, 0, 0, 1);
    check("R1", "wrong escape top", 80'(topPtr), 80'd7);
    check("R1", "wrong escape done", 80'(done), 80'd0);
    issue(1, 8'hD9, 8'hEF, 0, 2'b00, 0, 0, 0, 1);
    check("R1", "selector EF top", 80'(topPtr), 80'd7);
    issue(1, 8'hD9, 8'hE7, 0, 2'b00, 0, 0, 0, 1);
    check("R1", "selector E7 tags", 80'(tagValid), 80'h80);
    issue(0, 8'hD9, 8'hE8, 0, 2'b00, 0, 0, 0, 1);
    check("R1", "no strobe top", 80'(topPtr), 80'd7);
    check("R1", "no strobe done", 80'(done), 80'd0);
    check("R1", "image unchanged", 80'(stackImage != snap), 80'd0);
  endtask

  task automatic t_faults();
    logic [639:0] snap;
    doReset();
    issue(1, 8'hD9, 8'hE8, 0, 2'b00, 0, 0, 0, 1);
    snap = stackImage;
    issue(1, 8'hD9, 8'hE9, 1, 2'b00, 1, 1, 1, 1);
    check("R8", "lock priority", 80'({undefOp, devNotAvail, pendFault}), 80'b100);
    check("R9", "lock done", 80'(done), 80'd0);
    check("R9", "lock top", 80'(topPtr), 80'd7);
    @(negedge clk);
    check("R10", "undefOp falls", 80'(undefOp), 80'd0);
    issue(1, 8'hD9, 8'hEA, 0, 2'b00, 1, 0, 1, 1);
    check("R8", "emulation", 80'({undefOp, devNotAvail, pendFault}), 80'b010);
    issue(1, 8'hD9, 8'hEA, 0, 2'b00, 0, 1, 0, 1);
    check("R8", "task switched", 80'({undefOp, devNotAvail, pendFault}), 80'b010);
    issue(1, 8'hD9, 8'hEB, 0, 2'b00, 0, 0, 1, 1);
    check("R8", "pending", 80'({undefOp, devNotAvail, pendFault}), 80'b001);
    check("R9", "tags", 80'(tagValid), 80'h80);
    check("R9", "top", 80'(topPtr), 80'd7);
    check("R9", "image", 80'(stackImage != snap), 80'd0);
  endtask

  task automatic t_overflow();
    logic [639:0] snap;
    doReset();
    for (int k = 0; k < 8; k++) issue(1, 8'hD9, 8'hE8, 0, 2'b00, 0, 0, 0, 1);
    check("R4", "wrap top", 80'(topPtr), 80'd0);
    check("R4", "all tags", 80'(tagValid), 80'hFF);
    check("R5", "c1 before overflow", 80'(c1Flag), 80'd0);
    snap = stackImage;
    issue(1, 8'hD9, 8'hEB, 0, 2'b10, 0, 0, 0, 0);
    check("R6", "unmasked top", 80'(topPtr), 80'd0);
    check("R6", "unmasked image", 80'(stackImage != snap), 80'd0);
    check("R5", "unmasked c1", 80'(c1Flag), 80'd1);
    check("R5", "unmasked fault", 80'(stackFault), 80'd1);
    check("R10", "unmasked done", 80'(done), 80'd1);
    issue(1, 8'hD9, 8'hEB, 0, 2'b10, 0, 0, 0, 1);
    check("R6", "masked top", 80'(topPtr), 80'd7);
    check("R6", "masked nan", regAt(7), {1'b1, 15'h7FFF, 64'hC000000000000000});
    check("R5", "masked c1", 80'(c1Flag), 80'd1);
    check("R5", "masked fault", 80'(stackFault), 80'd1);
    @(negedge clk);
    check("R10", "fault falls", 80'(stackFault), 80'd0);
    snap = stackImage;
    issue(1, 8'hD9, 8'hED, 1, 2'b00, 0, 0, 0, 1);
    check("R8", "lock on full stack", 80'({undefOp, stackFault}), 80'b10);
    check("R9", "c1 kept", 80'(c1Flag), 80'd1);
    check("R9", "top kept", 80'(topPtr), 80'd7);
    check("R9", "image kept", 80'(stackImage != snap), 80'd0);
  endtask

  initial begin
    rstN = 0;
    idleInputs();
    t_reset();
    t_push_modes(2'b00);
    t_push_modes(2'b01);
    t_push_modes(2'b10);
    t_push_modes(2'b11);
    t_ignore();
    t_faults();
    t_overflow();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule